// File: doc/BRIEF.md
# Eight-Pin I/O Port with Interrupt-on-Change

This block is an 8-pin general-purpose I/O port held behind a byte-wide register file. A host reaches the registers over a plain synchronous bus: address, write data, write strobe, read strobe and a registered read-data return. Per-pin registers set the pin direction, input inversion, interrupt enable, compare mode and reference value, and the pull-up request. Output pins drive the value held in an output latch.

Inputs pass through a two-stage synchronizer and then the inversion stage. An interrupt engine watches the result. A pin can trigger on any change from its value in the previous cycle, or whenever it differs from its reference bit. On a trigger, the engine marks one pin in a one-hot flag register and freezes the port value in a snapshot register. Both stay frozen until the host clears them by reading the port or the snapshot. A configuration bit selects which of the two reads clears. The interrupt output's active level and its open-drain style drive are also configurable.

The bus has no back-pressure. Every strobe is accepted in the cycle it is presented. Read data is valid on the cycle after the read strobe, and the host must not raise both strobes in the same cycle. A continue input lets back-to-back accesses walk the register file from an internal pointer instead of the address input.

Top module: `pin_expander`

## Requirements
- R1: After reset, the direction register (0x00) reads 0xFF and every pin is an input (pin_oe = 0x00). All other registers read 0x00, and the interrupt pin shows its inactive level: irq_out = 1 and irq_oe = 1.
- R2: A 1 in direction bit i makes pin i an input (pin_oe[i] = 0); a 0 makes it an output. pin_out always equals the output latch. A write to 0x0A or to 0x09 loads the latch, and a read of 0x0A returns it.
- R3: A read of 0x09 returns the synchronized pin_in XOR the inversion register (0x01). Read data appears on the cycle after bus_re.
- R4: When interrupt-enable bit i (0x02) is 1, compare-mode bit i (0x04) is 0 and pin i is an input, any change of the pin's inverted value raises an interrupt.
- R5: When compare-mode bit i is 1, pin i raises an interrupt in every cycle its value differs from reference bit i (0x03), including again right after a clear. A change of that pin does not trigger on its own.
- R6: The flag register (0x07) is one-hot. When several pins trigger in one cycle, only the lowest-numbered one is recorded.
- R7: The snapshot register (0x08) holds the port value from the trigger cycle. While any flag bit is set, the flag and snapshot registers do not change, except when a clear occurs.
- R8: With configuration bit 0 at 0, a read of 0x09 clears the flags. With it at 1, a read of 0x08 clears them and a port read does not.
- R9: The interrupt is active while any flag bit is set. Configuration bit 1 = 1 makes the active level high; otherwise it is low. With configuration bit 2 = 1, irq_oe is 1 only while the interrupt is active; otherwise irq_oe is always 1.
- R10: pull_en always equals the pull-up register (0x06).
- R11: An access with bus_cont = 1 uses an internal pointer instead of bus_addr. The pointer is the last accessed address plus one, wrapping from 0x0A to 0x00. While configuration bit 5 is 1 (as it stood before the access), the pointer stays at the last accessed address.
- R12: Output pins and pins with interrupt enable 0 never set a flag. Writes to 0x07, 0x08 and to addresses above 0x0A are ignored. Reads above 0x0A return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_cont | input | 1 | Use the internal pointer instead of bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid on the cycle after bus_re |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Per-pin output enable |
| pull_en | output | 8 | Per-pin pull-up request |
| irq_out | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt drive enable |

## Verification
Two functions can fall in the same cycle here.

The first pair is a trigger and a frozen pending state. The bench flips two pins in one cycle, then flips a third while the interrupt is still pending. It judges by reading back the one-hot flag and the snapshot.

The second pair is a clearing read and a fresh trigger. The bench clears a compare-mode pin whose mismatch persists. It expects the flag to be set again on the next cycle, and it reads that flag back through the bus.

// File: rtl/pin_expander_pkg.sv
package pin_expander_pkg;
  localparam int unsigned AW = 4;

  // Register offsets; the clearing reads depend on PORT and SNAP.
  localparam logic [AW-1:0] A_DIR   = 4'h0;
  localparam logic [AW-1:0] A_INV   = 4'h1;
  localparam logic [AW-1:0] A_IEN   = 4'h2;
  localparam logic [AW-1:0] A_REF   = 4'h3;
  localparam logic [AW-1:0] A_CMODE = 4'h4;
  localparam logic [AW-1:0] A_CFG   = 4'h5;
  localparam logic [AW-1:0] A_PULL  = 4'h6;
  localparam logic [AW-1:0] A_FLAG  = 4'h7;
  localparam logic [AW-1:0] A_SNAP  = 4'h8;
  localparam logic [AW-1:0] A_PORT  = 4'h9;
  localparam logic [AW-1:0] A_LATCH = 4'hA;
  localparam logic [AW-1:0] A_LAST  = A_LATCH;

  // Configuration bit positions.
  localparam int unsigned CB_CLRSEL = 0;
  localparam int unsigned CB_ACTHI  = 1;
  localparam int unsigned CB_OD     = 2;
  localparam int unsigned CB_HOLD   = 5;
endpackage

// File: rtl/pin_expander_sync.sv
module pin_expander_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pin_expander_regs.sv
module pin_expander_regs
  import pin_expander_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_cont,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  port_val,
  input  logic [W-1:0]  flag,
  input  logic [W-1:0]  snap,
  output logic [W-1:0]  dir,
  output logic [W-1:0]  inv,
  output logic [W-1:0]  ien,
  output logic [W-1:0]  refv,
  output logic [W-1:0]  cmode,
  output logic [W-1:0]  pull,
  output logic [W-1:0]  latch,
  output logic          cfg_acthi,
  output logic          cfg_od,
  output logic          clr
);
  logic [W-1:0]  cfg;
  logic [AW-1:0] ptr, eff, ptr_nxt;
  logic [W-1:0]  rmux;

  assign eff     = bus_cont ? ptr : bus_addr;
  assign ptr_nxt = cfg[CB_HOLD] ? eff : ((eff == A_LAST) ? '0 : eff + 1'b1);

  assign clr = bus_re && (cfg[CB_CLRSEL] ? (eff == A_SNAP) : (eff == A_PORT));

  always_comb begin
    unique case (eff)
      A_DIR:   rmux = dir;
      A_INV:   rmux = inv;
      A_IEN:   rmux = ien;
      A_REF:   rmux = refv;
      A_CMODE: rmux = cmode;
      A_CFG:   rmux = cfg;
      A_PULL:  rmux = pull;
      A_FLAG:  rmux = flag;
      A_SNAP:  rmux = snap;
      A_PORT:  rmux = port_val;
      A_LATCH: rmux = latch;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir   <= '1;
      inv   <= '0;
      ien   <= '0;
      refv  <= '0;
      cmode <= '0;
      cfg   <= '0;
      pull  <= '0;
      latch <= '0;
      ptr   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we || bus_re) ptr <= ptr_nxt;
      if (bus_re) bus_rdata <= rmux;
      if (bus_we) begin
        unique case (eff)
          A_DIR:   dir   <= bus_wdata;
          A_INV:   inv   <= bus_wdata;
          A_IEN:   ien   <= bus_wdata;
          A_REF:   refv  <= bus_wdata;
          A_CMODE: cmode <= bus_wdata;
          A_CFG:   cfg   <= bus_wdata;
          A_PULL:  pull  <= bus_wdata;
          A_PORT:  latch <= bus_wdata;
          A_LATCH: latch <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign cfg_acthi = cfg[CB_ACTHI];
  assign cfg_od    = cfg[CB_OD];
endmodule

// File: rtl/pin_expander_irq.sv
module pin_expander_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] refv,
  input  logic [W-1:0] cmode,
  input  logic         clr,
  output logic [W-1:0] flag,
  output logic [W-1:0] snap
);
  logic [W-1:0] prev, hit, pick;
  logic [W:0]   seen;

  assign hit = ien & dir & ((cmode & (val ^ refv)) | (~cmode & (val ^ prev)));

  // Priority chain: keep only the lowest-numbered triggering pin.
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_pick
    assign pick[i]   = hit[i] & ~seen[i];
    assign seen[i+1] = seen[i] | hit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      flag <= '0;
      snap <= '0;
    end else begin
      prev <= val;
      if (clr) begin
        flag <= '0;
      end else if (flag == '0 && seen[W]) begin
        flag <= pick;
        snap <= val;
      end
    end
  end
endmodule

// File: rtl/pin_expander.sv
module pin_expander
  import pin_expander_pkg::*;
#(
  parameter int unsigned NPIN        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_cont,
  input  logic [NPIN-1:0] bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pull_en,
  output logic            irq_out,
  output logic            irq_oe
);
  logic [NPIN-1:0] sync_q, port_val;
  logic [NPIN-1:0] dir, inv, ien, refv, cmode, pull, latch;
  logic [NPIN-1:0] irq_flag, irq_snap;
  logic            cfg_acthi, cfg_od, clr_hit, active;

  pin_expander_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  assign port_val = sync_q ^ inv;

  pin_expander_regs #(.W(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_cont(bus_cont), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .port_val(port_val), .flag(irq_flag), .snap(irq_snap),
    .dir(dir), .inv(inv), .ien(ien), .refv(refv), .cmode(cmode),
    .pull(pull), .latch(latch),
    .cfg_acthi(cfg_acthi), .cfg_od(cfg_od), .clr(clr_hit)
  );

  pin_expander_irq #(.W(NPIN)) u_irq (
    .clk(clk), .rst_n(rst_n), .val(port_val), .dir(dir), .ien(ien),
    .refv(refv), .cmode(cmode), .clr(clr_hit),
    .flag(irq_flag), .snap(irq_snap)
  );

  assign pin_oe  = ~dir;
  assign pin_out = latch;
  assign pull_en = pull;
  assign active  = |irq_flag;
  assign irq_out = active ? cfg_acthi : ~cfg_acthi;
  assign irq_oe  = cfg_od ? active : 1'b1;
endmodule

// File: rtl/pin_expander_chk.sv
module pin_expander_chk
  import pin_expander_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_cont,
  input logic [NPIN-1:0] bus_wdata,
  input logic            bus_we,
  input logic            bus_re,
  input logic [NPIN-1:0] bus_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] irq_flag,
  input logic [NPIN-1:0] irq_snap,
  input logic            clr_hit
);
  // R6
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_flag));

  // R7
  pending_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_flag) && !clr_hit |=> $stable(irq_flag) && $stable(irq_snap));

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> irq_flag == '0);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !bus_cont && bus_addr == A_DIR |=> pin_oe == ~$past(bus_wdata));

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !bus_we && !bus_cont && bus_addr == A_LATCH |=> bus_rdata == pin_out);
endmodule

bind pin_expander pin_expander_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cont(bus_cont),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_flag(irq_flag), .irq_snap(irq_snap), .clr_hit(clr_hit)
);

// File: tb/pin_expander_bench.sv
`timescale 1ns/1ps
module pin_expander_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_cont = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, pull_en;
  logic       irq_out, irq_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_expander u_pin_expander (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cont(bus_cont),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  // {op(2): 1 write, 2 read; addr(4); data(8); expected(8)}
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {2'd2, 4'h0, 8'h00, 8'hFF},   // R1 direction reset
    {2'd2, 4'h5, 8'h00, 8'h00},   // R1 configuration reset
    {2'd2, 4'h7, 8'h00, 8'h00},   // R1 flag reset
    {2'd2, 4'hA, 8'h00, 8'h00},   // R1 latch reset
    {2'd1, 4'h0, 8'h0F, 8'h00},
    {2'd2, 4'h0, 8'h00, 8'h0F},   // R2
    {2'd1, 4'hA, 8'hA5, 8'h00},
    {2'd2, 4'hA, 8'h00, 8'hA5},   // R2
    {2'd1, 4'h9, 8'h3C, 8'h00},
    {2'd2, 4'hA, 8'h00, 8'h3C},   // R2 port write loads latch
    {2'd1, 4'h6, 8'h81, 8'h00},
    {2'd2, 4'h6, 8'h00, 8'h81},   // R10
    {2'd1, 4'h3, 8'h55, 8'h00},
    {2'd2, 4'h3, 8'h00, 8'h55},
    {2'd1, 4'h7, 8'hFF, 8'h00},
    {2'd2, 4'h7, 8'h00, 8'h00},   // R12 flag write ignored
    {2'd1, 4'h8, 8'hFF, 8'h00},
    {2'd2, 4'h8, 8'h00, 8'h00},   // R12 snapshot write ignored
    {2'd1, 4'hC, 8'h12, 8'h00},
    {2'd2, 4'hC, 8'h00, 8'h00},   // R12 out-of-range address
    {2'd1, 4'h3, 8'h00, 8'h00},
    {2'd2, 4'h3, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_cont = c;
    @(negedge clk);
    bus_we = 1'b0; bus_cont = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic c, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_cont = c;
    @(negedge clk);
    bus_re = 1'b0; bus_cont = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pull_en", pull_en, 8'h00);
    chk("R1 irq_out", {7'd0, irq_out}, 8'h01);
    chk("R1 irq_oe", {7'd0, irq_oe}, 8'h01);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][21:20] == 2'd1) wr(VEC[k][19:16], VEC[k][15:8], 1'b0);
      else begin
        rd(VEC[k][19:16], 1'b0, v);
        chk("R1 R2 R10 R12 table", v, VEC[k][7:0]);
      end
    end
    chk("R2 pin_oe", pin_oe, 8'hF0);
    chk("R2 pin_out", pin_out, 8'h3C);
    chk("R10 pull_en", pull_en, 8'h81);

    // R3: synchronized read with inversion
    wr(4'h0, 8'hFF, 1'b0);
    pin_in = 8'h5A; settle();
    rd(4'h9, 1'b0, v); chk("R3 port", v, 8'h5A);
    wr(4'h1, 8'h0F, 1'b0);
    rd(4'h9, 1'b0, v); chk("R3 inverted port", v, 8'h55);
    wr(4'h1, 8'h00, 1'b0);

    // R4 R6 R7: two pins in one cycle, then a third while pending
    wr(4'h2, 8'hFF, 1'b0);
    settle();
    chk("R4 idle irq", {7'd0, irq_out}, 8'h01);
    pin_in = 8'h72; settle();
    chk("R4 irq active low", {7'd0, irq_out}, 8'h00);
    rd(4'h7, 1'b0, v); chk("R6 lowest flag", v, 8'h08);
    rd(4'h8, 1'b0, v); chk("R7 snapshot", v, 8'h72);
    pin_in = 8'h73; settle();
    rd(4'h7, 1'b0, v); chk("R7 flag frozen", v, 8'h08);
    rd(4'h8, 1'b0, v); chk("R7 snapshot frozen", v, 8'h72);
    rd(4'h9, 1'b0, v); chk("R8 port read", v, 8'h73);
    settle();
    chk("R8 irq released", {7'd0, irq_out}, 8'h01);
    rd(4'h7, 1'b0, v); chk("R8 flag cleared", v, 8'h00);

    // R12: output pin and disabled pin never flag
    wr(4'h0, 8'hFE, 1'b0);
    pin_in = 8'h72; settle();
    rd(4'h7, 1'b0, v); chk("R12 output pin", v, 8'h00);
    wr(4'h0, 8'hFF, 1'b0);
    wr(4'h2, 8'hFD, 1'b0);
    pin_in = 8'h70; settle();
    rd(4'h7, 1'b0, v); chk("R12 disabled pin", v, 8'h00);
    chk("R12 irq idle", {7'd0, irq_out}, 8'h01);
    wr(4'h2, 8'hFF, 1'b0);

    // R5: compare mode re-triggers after a clear while mismatch lasts
    wr(4'h3, 8'h80, 1'b0);
    wr(4'h4, 8'h80, 1'b0);
    settle();
    rd(4'h7, 1'b0, v); chk("R5 mismatch flag", v, 8'h80);
    rd(4'h9, 1'b0, v);
    rd(4'h7, 1'b0, v); chk("R5 re-trigger after clear", v, 8'h80);
    chk("R5 irq active", {7'd0, irq_out}, 8'h00);
    pin_in = 8'hF0; settle();
    rd(4'h9, 1'b0, v);
    settle();
    rd(4'h7, 1'b0, v); chk("R5 match quiet", v, 8'h00);

    // R8: clear selected by snapshot read
    wr(4'h5, 8'h01, 1'b0);
    pin_in = 8'hF4; settle();
    rd(4'h7, 1'b0, v); chk("R8 flag set", v, 8'h04);
    rd(4'h9, 1'b0, v); chk("R8 port value", v, 8'hF4);
    rd(4'h7, 1'b0, v); chk("R8 port read keeps flag", v, 8'h04);
    rd(4'h8, 1'b0, v); chk("R8 snapshot value", v, 8'hF4);
    rd(4'h7, 1'b0, v); chk("R8 snapshot read clears", v, 8'h00);

    // R9: level and drive style
    wr(4'h5, 8'h03, 1'b0);
    chk("R9 idle high-active", {7'd0, irq_out}, 8'h00);
    pin_in = 8'hF0; settle();
    chk("R9 active high", {7'd0, irq_out}, 8'h01);
    wr(4'h5, 8'h07, 1'b0);
    chk("R9 od active drives", {7'd0, irq_oe}, 8'h01);
    rd(4'h8, 1'b0, v);
    settle();
    chk("R9 od idle released", {7'd0, irq_oe}, 8'h00);
    wr(4'h5, 8'h00, 1'b0);
    chk("R9 push-pull idle", {6'd0, irq_oe, irq_out}, 8'h03);

    // R11: pointer walk, wrap and hold
    wr(4'hA, 8'h11, 1'b0);
    wr(4'h0, 8'h22, 1'b1);
    chk("R11 wrap to direction", pin_oe, 8'hDD);
    rd(4'hA, 1'b0, v); chk("R11 latch kept", v, 8'h11);
    wr(4'h5, 8'h20, 1'b0);
    rd(4'h0, 1'b1, v); chk("R11 next address", v, 8'h81);
    rd(4'h0, 1'b1, v); chk("R11 held address", v, 8'h81);
    wr(4'h5, 8'h00, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule